// File: doc/BRIEF.md
# Link Training Sequencer

This block runs the transmit side of a serial display link training handshake for a link of one, two or four lanes. After a start pulse it configures the sink and then moves through clock recovery and channel equalisation. Whatever the result, it ends with a finish step and reports pass or fail with a one-cycle completion pulse. Each time it polls, it reads a snapshot of per-lane status and the sink's drive requests. From that snapshot it derives one drive setting (voltage swing plus pre-emphasis), which it presents to the local transmitter and writes to the sink.

All sink accesses go through an abstract register port. A request is held until the environment acknowledges it for one cycle. On a read, the acknowledge can carry an error flag. The source side is modelled as a mode code and a drive byte; the analog front end is outside the block. Wait times are given in microseconds and counted in clock cycles.

Top module: `link_train_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `reg_req` are 0, `src_mode` is 0 (idle) and `tx_drive` is 0.
- R2: After start, configuration is written in this order: lane-count address 0x01, rate address 0x00, then pattern address 0x02 with value 0. The lane-count byte is the lane count, with bit 7 set only when the sink revision is 0x11 or higher and the enhanced-framing capability input is 1. `src_mode` becomes 1 (training start) before the pattern clear. Each request holds its address and data until it is acknowledged.
- R3: Clock recovery sets `src_mode` to 2, writes value 1 to address 0x02, then writes drive byte 0 to drive address 0x03.
- R4: A new drive byte uses bits [1:0] for swing, bit 2 as the swing-at-max flag, bits [4:3] for pre-emphasis and bit 5 as the pre-emphasis-at-max flag. Swing and pre-emphasis are the maxima of the requests over the active lanes only. Each flag is set when its level equals 3. The status word carries 7 bits per lane i at offset 7i: bit 0 clock-recovered, bit 1 equalised, bit 2 symbol-locked, bits 4:3 requested swing, bits 6:5 requested pre-emphasis. Bit 28 is interlane alignment.
- R5: Clock recovery succeeds when every active lane reports clock-recovered. Equalisation then begins.
- R6: Equalisation writes pattern 3 and sets `src_mode` to 4 when the pattern-3 capability input is 1. Otherwise it writes pattern 2 and sets `src_mode` to 3.
- R7: Clock recovery counts consecutive passes that leave lane-0 swing unchanged from the previous pass. It fails when that count reaches 5, on the sixth status read when the request never changes.
- R8: Clock recovery fails as soon as the current drive already carries the swing-at-max flag and recovery is not reported. A recovery report in the same evaluation takes priority over this abort.
- R9: Equalisation fails on the seventh unsuccessful status read, after six drive adjustments.
- R10: Equalisation succeeds only when every active lane reports clock-recovered, equalised and symbol-locked and the alignment bit is set. Inactive lanes are ignored.
- R11: A read acknowledged with `reg_err` ends the current phase as a failure.
- R12: The finish step always runs. It writes value 0 to address 0x02, sets `src_mode` to 5, then pulses `done` for one cycle with `pass` showing the result.
- R13: The first clock-recovery poll is issued no earlier than (SETTLE_US + POLL_US) × CLK_MHZ cycles after the initial drive write is acknowledged. Later polls wait POLL_US × CLK_MHZ cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Pulse to begin a training run |
| cfg_lanes | input | 3 | Active lane count (1, 2 or 4) |
| cfg_sink_rev | input | 8 | Sink revision code |
| cfg_enh_cap | input | 1 | Sink supports enhanced framing |
| cfg_tp3 | input | 1 | Sink supports pattern 3 |
| cfg_rate | input | 8 | Link rate code written to the sink |
| reg_req | output | 1 | Register access request, held until ack |
| reg_we | output | 1 | 1 = write, 0 = status read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | One-cycle acknowledge |
| reg_err | input | 1 | Read failed, valid with ack |
| reg_rdata | input | MAX_LANES*7+1 | Status snapshot, valid with ack |
| tx_drive | output | 8 | Drive byte for the local transmitter |
| src_mode | output | 3 | 0 idle, 1 start, 2/3/4 pattern 1/2/3, 5 complete |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last run |

## Verification
In one clock-recovery evaluation, the success test and the max-swing abort can both be true. To provoke this, the sink first requests swing level 3 without reporting recovery, which drives the setting to its maximum. On the next read it reports recovery. The run must go on into equalisation and pass, not abort. The same-swing counter reaching its limit is also checked against a recovery arriving in time, through separate runs whose read counts are compared with the expected abort point.

// File: rtl/lts_pkg.sv
package lts_pkg;
   localparam int LANE_FW = 7;
   localparam int F_CR    = 0;
   localparam int F_EQ    = 1;
   localparam int F_LOCK  = 2;
   localparam int F_V     = 3;
   localparam int F_P     = 5;

   localparam logic [7:0] ADDR_RATE    = 8'h00;
   localparam logic [7:0] ADDR_LANES   = 8'h01;
   localparam logic [7:0] ADDR_PATTERN = 8'h02;
   localparam logic [7:0] ADDR_DRIVE   = 8'h03;
   localparam logic [7:0] ADDR_STATUS  = 8'h10;

   typedef enum logic [2:0] {
      SRC_IDLE  = 3'd0,
      SRC_START = 3'd1,
      SRC_PAT1  = 3'd2,
      SRC_PAT2  = 3'd3,
      SRC_PAT3  = 3'd4,
      SRC_DONE  = 3'd5
   } src_mode_e;

   typedef enum logic [4:0] {
      S_IDLE, S_LANES, S_RATE, S_CLR,
      S_CR_PAT, S_CR_DRV, S_CR_WAIT, S_CR_RD, S_CR_EVAL,
      S_EQ_PAT, S_EQ_WAIT, S_EQ_RD, S_EQ_EVAL, S_EQ_DRV,
      S_FIN_WAIT, S_FIN_CLR
   } fsm_e;
endpackage

// File: rtl/lts_status_chk.sv
module lts_status_chk
   import lts_pkg::*;
#(
   parameter int MAX_LANES = 4
) (
   input  logic [MAX_LANES*LANE_FW:0] status,
   input  logic [2:0]                 lanes,
   output logic                       cr_ok,
   output logic                       eq_ok
);
   localparam int ALIGN_BIT = MAX_LANES*LANE_FW;

   logic [MAX_LANES-1:0] lane_cr;
   logic [MAX_LANES-1:0] lane_eq;

   for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
      logic active;
      assign active     = lanes > 3'(i);
      assign lane_cr[i] = !active || status[i*LANE_FW+F_CR];
      assign lane_eq[i] = !active || (status[i*LANE_FW+F_CR] &&
                                      status[i*LANE_FW+F_EQ] &&
                                      status[i*LANE_FW+F_LOCK]);
   end

   assign cr_ok = &lane_cr;
   assign eq_ok = (&lane_eq) && status[ALIGN_BIT];
endmodule

// File: rtl/lts_drive_calc.sv
module lts_drive_calc
   import lts_pkg::*;
#(
   parameter int MAX_LANES = 4
) (
   input  logic [MAX_LANES*LANE_FW:0] status,
   input  logic [2:0]                 lanes,
   output logic [7:0]                 drive
);
   logic [1:0] v_max;
   logic [1:0] p_max;

   always_comb begin
      v_max = 2'd0;
      p_max = 2'd0;
      for (int i = 0; i < MAX_LANES; i++) begin
         if (lanes > 3'(i)) begin
            if (status[i*LANE_FW+F_V +: 2] > v_max) v_max = status[i*LANE_FW+F_V +: 2];
            if (status[i*LANE_FW+F_P +: 2] > p_max) p_max = status[i*LANE_FW+F_P +: 2];
         end
      end
      drive = {2'b00, (p_max == 2'd3), p_max, (v_max == 2'd3), v_max};
   end
endmodule

// File: rtl/lts_wait_ctr.sv
module lts_wait_ctr #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
      else          cnt <= '0;
   end

   assign hit = run && (cnt == limit - 1'b1);

   p_cnt_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < limit));
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
   import lts_pkg::*;
#(
   parameter int MAX_LANES     = 4,
   parameter int CLK_MHZ       = 200,
   parameter int SETTLE_US     = 400,
   parameter int POLL_US       = 100,
   parameter int CR_SAME_LIMIT = 5,
   parameter int EQ_TRY_LIMIT  = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [2:0]                 cfg_lanes,
   input  logic [7:0]                 cfg_sink_rev,
   input  logic                       cfg_enh_cap,
   input  logic                       cfg_tp3,
   input  logic [7:0]                 cfg_rate,
   output logic                       reg_req,
   output logic                       reg_we,
   output logic [7:0]                 reg_addr,
   output logic [7:0]                 reg_wdata,
   input  logic                       reg_ack,
   input  logic                       reg_err,
   input  logic [MAX_LANES*7:0]       reg_rdata,
   output logic [7:0]                 tx_drive,
   output logic [2:0]                 src_mode,
   output logic                       busy,
   output logic                       done,
   output logic                       pass
);
   localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
   localparam int POLL_CYC   = POLL_US * CLK_MHZ;
   localparam int CNT_W      = $clog2(SETTLE_CYC + POLL_CYC + 1);
   localparam int ST_W       = MAX_LANES*LANE_FW + 1;
   localparam int CS_W       = $clog2(CR_SAME_LIMIT + 1);
   localparam int EQ_W       = $clog2(EQ_TRY_LIMIT + 2);

   if (!(MAX_LANES == 1 || MAX_LANES == 2 || MAX_LANES == 4)) begin : g_bad_lanes
      $error("MAX_LANES must be 1, 2 or 4");
   end
   if (SETTLE_CYC < 1 || POLL_CYC < 1) begin : g_bad_wait
      $error("wait times must be at least one cycle");
   end
   if (CR_SAME_LIMIT < 1 || EQ_TRY_LIMIT < 0) begin : g_bad_limits
      $error("retry limits out of range");
   end

   fsm_e            st;
   src_mode_e       src_q;
   logic [2:0]      lanes_q;
   logic [7:0]      lanes_byte_q;
   logic [7:0]      rate_q;
   logic            tp3_q;
   logic [7:0]      drive_q;
   logic [ST_W-1:0] stat_q;
   logic [1:0]      prev_v;
   logic            prev_valid;
   logic [CS_W-1:0] cr_same;
   logic [EQ_W-1:0] eq_tries;
   logic            cr_first;
   logic            pass_q;

   logic            cr_ok, eq_ok;
   logic [7:0]      drive_next;
   logic            w_run, w_hit;
   logic [CNT_W-1:0] w_limit;

   lts_status_chk #(.MAX_LANES(MAX_LANES)) u_chk (
      .status(stat_q), .lanes(lanes_q), .cr_ok(cr_ok), .eq_ok(eq_ok));

   lts_drive_calc #(.MAX_LANES(MAX_LANES)) u_calc (
      .status(stat_q), .lanes(lanes_q), .drive(drive_next));

   lts_wait_ctr #(.W(CNT_W)) u_wait (
      .clk(clk), .rst_n(rst_n), .run(w_run), .limit(w_limit), .hit(w_hit));

   always_comb begin
      w_run   = (st == S_CR_WAIT) || (st == S_EQ_WAIT) || (st == S_FIN_WAIT);
      w_limit = CNT_W'(POLL_CYC);
      if (st == S_CR_WAIT && cr_first) w_limit = CNT_W'(SETTLE_CYC + POLL_CYC);
      if (st == S_FIN_WAIT)            w_limit = CNT_W'(SETTLE_CYC);
   end

   always_comb begin
      reg_req   = 1'b1;
      reg_we    = 1'b1;
      reg_addr  = ADDR_PATTERN;
      reg_wdata = 8'h00;
      case (st)
         S_LANES:           begin reg_addr = ADDR_LANES; reg_wdata = lanes_byte_q; end
         S_RATE:            begin reg_addr = ADDR_RATE;  reg_wdata = rate_q;       end
         S_CLR, S_FIN_CLR:  reg_wdata = 8'h00;
         S_CR_PAT:          reg_wdata = 8'h01;
         S_EQ_PAT:          reg_wdata = tp3_q ? 8'h03 : 8'h02;
         S_CR_DRV, S_EQ_DRV: begin reg_addr = ADDR_DRIVE; reg_wdata = drive_q; end
         S_CR_RD, S_EQ_RD:  begin reg_we = 1'b0; reg_addr = ADDR_STATUS; end
         default:           begin reg_req = 1'b0; reg_addr = 8'h00; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= S_IDLE;
         src_q        <= SRC_IDLE;
         lanes_q      <= 3'd1;
         lanes_byte_q <= 8'h00;
         rate_q       <= 8'h00;
         tp3_q        <= 1'b0;
         drive_q      <= 8'h00;
         stat_q       <= '0;
         prev_v       <= 2'd0;
         prev_valid   <= 1'b0;
         cr_same      <= '0;
         eq_tries     <= '0;
         cr_first     <= 1'b0;
         pass_q       <= 1'b0;
         busy         <= 1'b0;
         done         <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            S_IDLE: if (start) begin
               lanes_q      <= cfg_lanes;
               lanes_byte_q <= {(cfg_sink_rev >= 8'h11) && cfg_enh_cap, 4'b0000, cfg_lanes};
               rate_q       <= cfg_rate;
               tp3_q        <= cfg_tp3;
               drive_q      <= 8'h00;
               pass_q       <= 1'b0;
               busy         <= 1'b1;
               st           <= S_LANES;
            end
            S_LANES: if (reg_ack) st <= S_RATE;
            S_RATE:  if (reg_ack) begin src_q <= SRC_START; st <= S_CLR; end
            S_CLR:   if (reg_ack) begin src_q <= SRC_PAT1;  st <= S_CR_PAT; end
            S_CR_PAT: if (reg_ack) begin
               drive_q    <= 8'h00;
               cr_same    <= '0;
               prev_valid <= 1'b0;
               cr_first   <= 1'b1;
               st         <= S_CR_DRV;
            end
            S_CR_DRV:  if (reg_ack) st <= S_CR_WAIT;
            S_CR_WAIT: if (w_hit) begin cr_first <= 1'b0; st <= S_CR_RD; end
            S_CR_RD: if (reg_ack) begin
               if (reg_err) st <= S_FIN_WAIT;
               else begin stat_q <= reg_rdata; st <= S_CR_EVAL; end
            end
            S_CR_EVAL: begin
               if (cr_ok) begin
                  src_q    <= tp3_q ? SRC_PAT3 : SRC_PAT2;
                  eq_tries <= '0;
                  st       <= S_EQ_PAT;
               end else if (drive_q[2]) begin
                  st <= S_FIN_WAIT;
               end else if (prev_valid && drive_q[1:0] == prev_v &&
                            cr_same == CS_W'(CR_SAME_LIMIT - 1)) begin
                  st <= S_FIN_WAIT;
               end else begin
                  cr_same    <= (prev_valid && drive_q[1:0] == prev_v) ? cr_same + 1'b1 : '0;
                  prev_v     <= drive_q[1:0];
                  prev_valid <= 1'b1;
                  drive_q    <= drive_next;
                  st         <= S_CR_DRV;
               end
            end
            S_EQ_PAT:  if (reg_ack) st <= S_EQ_WAIT;
            S_EQ_WAIT: if (w_hit) st <= S_EQ_RD;
            S_EQ_RD: if (reg_ack) begin
               if (reg_err) st <= S_FIN_WAIT;
               else begin stat_q <= reg_rdata; st <= S_EQ_EVAL; end
            end
            S_EQ_EVAL: begin
               if (eq_ok) begin
                  pass_q <= 1'b1;
                  st     <= S_FIN_WAIT;
               end else if (eq_tries > EQ_W'(EQ_TRY_LIMIT)) begin
                  st <= S_FIN_WAIT;
               end else begin
                  drive_q  <= drive_next;
                  eq_tries <= eq_tries + 1'b1;
                  st       <= S_EQ_DRV;
               end
            end
            S_EQ_DRV:   if (reg_ack) st <= S_EQ_WAIT;
            S_FIN_WAIT: if (w_hit) st <= S_FIN_CLR;
            S_FIN_CLR: if (reg_ack) begin
               src_q <= SRC_DONE;
               done  <= 1'b1;
               busy  <= 1'b0;
               st    <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign tx_drive = drive_q;
   assign src_mode = src_q;
   assign pass     = pass_q;

   p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_wdata)));

   p_pat1_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_PAT1 && $past(src_q) != SRC_PAT1) |-> ($past(src_q) == SRC_START));

   p_flag_swing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_drive[1:0] == 2'd3) |-> tx_drive[2]);

   p_same_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cr_same < CS_W'(CR_SAME_LIMIT));

   p_eq_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eq_tries <= EQ_W'(EQ_TRY_LIMIT + 1));

   p_pass_from_eq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass_q) |-> ($past(st) == S_EQ_EVAL));

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
endmodule

// File: tb/link_train_seq_test.sv
`timescale 1ns/1ps
module link_train_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  cfg_lanes = 3'd1;
   logic [7:0]  cfg_sink_rev = 8'h00;
   logic        cfg_enh_cap = 1'b0;
   logic        cfg_tp3 = 1'b0;
   logic [7:0]  cfg_rate = 8'h00;
   logic        reg_req, reg_we;
   logic [7:0]  reg_addr, reg_wdata;
   logic        reg_ack;
   logic        reg_err;
   logic [28:0] reg_rdata;
   logic [7:0]  tx_drive;
   logic [2:0]  src_mode;
   logic        busy, done, pass;

   always #2.5 clk = ~clk;

   link_train_seq #(.CLK_MHZ(200), .SETTLE_US(1), .POLL_US(1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_lanes(cfg_lanes),
      .cfg_sink_rev(cfg_sink_rev), .cfg_enh_cap(cfg_enh_cap), .cfg_tp3(cfg_tp3),
      .cfg_rate(cfg_rate), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err),
      .reg_rdata(reg_rdata), .tx_drive(tx_drive), .src_mode(src_mode),
      .busy(busy), .done(done), .pass(pass));

   int n_chk = 0, n_bad = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // sink model controls
   logic [1:0] adj_v [4];
   logic [1:0] adj_p [4];
   int  st_lanes, cr_ok_at, eq_ok_at, err_cr, err_eq;
   bit  st_align;
   // observation
   int  phase, cr_idx, eq_idx, n_wr, n_drv, t_drv, t_rd;
   logic [7:0]  last_lanes, last_rate, last_drv, first_drv;
   logic [31:0] pat_hist, src_hist;
   logic [39:0] addr_hist;
   logic [2:0]  src_prev = 3'd0;

   task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
      n_chk++;
      if (a !== e) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", r, a, e);
      end
   endtask

   function automatic logic [28:0] mk(input bit eqph, input int idx);
      logic [28:0] w;
      w = '0;
      for (int i = 0; i < 4; i++) begin
         w[i*7+3 +: 2] = adj_v[i];
         w[i*7+5 +: 2] = adj_p[i];
         if (i < st_lanes) begin
            if (eqph || idx >= cr_ok_at) w[i*7] = 1'b1;
            if (eqph && idx >= eq_ok_at) begin w[i*7+1] = 1'b1; w[i*7+2] = 1'b1; end
         end
      end
      if (eqph && idx >= eq_ok_at && st_align) w[28] = 1'b1;
      return w;
   endfunction

   // register responder: one-cycle ack, gap of one cycle between acks
   initial begin
      reg_ack = 1'b0; reg_err = 1'b0; reg_rdata = '0;
      forever begin
         @(negedge clk);
         if (reg_ack) begin
            reg_ack = 1'b0; reg_err = 1'b0;
         end else if (rst_n && reg_req) begin
            reg_ack = 1'b1;
            if (reg_we) begin
               if (n_wr < 5) addr_hist = {addr_hist[31:0], reg_addr};
               n_wr++;
               case (reg_addr)
                  8'h01: last_lanes = reg_wdata;
                  8'h00: last_rate  = reg_wdata;
                  8'h02: begin
                     pat_hist = {pat_hist[27:0], 4'h8 | reg_wdata[3:0]};
                     phase = reg_wdata;
                     if (reg_wdata == 8'd1) cr_idx = 0;
                     if (reg_wdata >= 8'd2) eq_idx = 0;
                  end
                  8'h03: begin
                     n_drv++; last_drv = reg_wdata;
                     if (n_drv == 1) begin first_drv = reg_wdata; t_drv = cyc; end
                  end
                  default: ;
               endcase
            end else if (phase == 1) begin
               if (cr_idx == 0) t_rd = cyc;
               reg_err   = (cr_idx == err_cr);
               reg_rdata = mk(1'b0, cr_idx);
               cr_idx++;
            end else begin
               reg_err   = (eq_idx == err_eq);
               reg_rdata = mk(1'b1, eq_idx);
               eq_idx++;
            end
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (src_mode != src_prev) begin
         src_hist = {src_hist[27:0], 1'b0, src_mode};
         src_prev = src_mode;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hang expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   task automatic set_adj(input logic [1:0] v0, p0, v1, p1, v2, p2, v3, p3);
      adj_v[0] = v0; adj_p[0] = p0; adj_v[1] = v1; adj_p[1] = p1;
      adj_v[2] = v2; adj_p[2] = p2; adj_v[3] = v3; adj_p[3] = p3;
   endtask

   task automatic run(input logic [2:0] ln, input logic [7:0] rev, input logic enh,
                      input logic tp3, input logic [7:0] rate);
      phase = 0; cr_idx = 0; eq_idx = 0; n_wr = 0; n_drv = 0; t_drv = 0; t_rd = 0;
      pat_hist = 0; src_hist = 0; addr_hist = 0; last_drv = 8'hEE; first_drv = 8'hEE;
      cfg_lanes = ln; cfg_sink_rev = rev; cfg_enh_cap = enh; cfg_tp3 = tp3; cfg_rate = rate;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 busy", busy, 0);      chk("R1 done", done, 0);
      chk("R1 pass", pass, 0);      chk("R1 req", reg_req, 0);
      chk("R1 src", src_mode, 0);   chk("R1 drive", tx_drive, 0);
   endtask

   task automatic t_happy;
      set_adj(1,1, 1,1, 1,1, 1,1);
      st_lanes = 4; st_align = 1; cr_ok_at = 1; eq_ok_at = 0; err_cr = -1; err_eq = -1;
      run(3'd4, 8'h12, 1'b1, 1'b0, 8'h0A);
      chk("R2 order", addr_hist, 40'h01_00_02_02_03);
      chk("R2 lanes enh", last_lanes, 8'h84);
      chk("R2 rate", last_rate, 8'h0A);
      chk("R3 first drive", first_drv, 8'h00);
      chk("R4 adjusted drive", last_drv, 8'h09);
      chk("R5 cr reads", cr_idx, 2);
      chk("R6 pattern 2", pat_hist, 32'h89A8);
      chk("R12 src seq", src_hist, 32'h1235);
      chk("R12 pass", pass, 1);
      chk("R13 first poll gap ok", (t_rd - t_drv >= 400) && (t_rd - t_drv <= 403), 1);
      @(negedge clk);
      chk("R12 done single", done, 0);
   endtask

   task automatic t_tp3_inactive;
      set_adj(1,0, 0,2, 3,3, 3,3);
      st_lanes = 2; st_align = 1; cr_ok_at = 1; eq_ok_at = 0; err_cr = -1; err_eq = -1;
      run(3'd2, 8'h10, 1'b1, 1'b1, 8'h14);
      chk("R2 lanes no enh", last_lanes, 8'h02);
      chk("R4 max over active lanes", last_drv, 8'h11);
      chk("R6 pattern 3", pat_hist, 32'h89B8);
      chk("R6 src pat3", src_hist, 32'h1245);
      chk("R10 inactive ignored pass", pass, 1);
   endtask

   task automatic t_cr_same;
      set_adj(0,0, 0,0, 0,0, 0,0);
      st_lanes = 1; st_align = 1; cr_ok_at = 1000; eq_ok_at = 0; err_cr = -1; err_eq = -1;
      run(3'd1, 8'h11, 1'b0, 1'b0, 8'h06);
      chk("R7 cr reads", cr_idx, 6);
      chk("R7 drive writes", n_drv, 6);
      chk("R7 fail", pass, 0);
      chk("R12 finish after cr fail", pat_hist, 32'h898);
      chk("R12 src after cr fail", src_hist, 32'h125);
   endtask

   task automatic t_max_swing;
      set_adj(3,3, 0,0, 0,0, 0,0);
      st_lanes = 4; st_align = 1; cr_ok_at = 1000; eq_ok_at = 0; err_cr = -1; err_eq = -1;
      run(3'd4, 8'h11, 1'b0, 1'b0, 8'h0A);
      chk("R8 abort reads", cr_idx, 2);
      chk("R4 both max flags", last_drv, 8'h3F);
      chk("R8 fail", pass, 0);
      // success in the same evaluation as an at-max drive wins
      cr_ok_at = 1;
      run(3'd4, 8'h11, 1'b0, 1'b0, 8'h0A);
      chk("R8 ok beats abort", pass, 1);
      chk("R5 eq reached", eq_idx, 1);
   endtask

   task automatic t_eq_limit;
      set_adj(1,0, 1,0, 1,0, 1,0);
      st_lanes = 4; st_align = 1; cr_ok_at = 0; eq_ok_at = 1000; err_cr = -1; err_eq = -1;
      run(3'd4, 8'h11, 1'b0, 1'b0, 8'h0A);
      chk("R9 eq reads", eq_idx, 7);
      chk("R9 drive writes", n_drv, 7);
      chk("R9 fail", pass, 0);
   endtask

   task automatic t_align;
      set_adj(0,0, 0,0, 0,0, 0,0);
      st_lanes = 2; st_align = 0; cr_ok_at = 0; eq_ok_at = 0; err_cr = -1; err_eq = -1;
      run(3'd2, 8'h11, 1'b0, 1'b0, 8'h0A);
      chk("R10 no align fails", pass, 0);
      st_lanes = 1; st_align = 1;
      run(3'd2, 8'h11, 1'b0, 1'b0, 8'h0A);
      chk("R10 one active lane short fails", pass, 0);
   endtask

   task automatic t_rd_err;
      set_adj(0,0, 0,0, 0,0, 0,0);
      st_lanes = 4; st_align = 1; cr_ok_at = 0; eq_ok_at = 1000; err_cr = 0; err_eq = -1;
      run(3'd4, 8'h11, 1'b0, 1'b0, 8'h0A);
      chk("R11 cr err reads", cr_idx, 1);
      chk("R11 no eq", eq_idx, 0);
      chk("R11 fail", pass, 0);
      chk("R12 finish after err", pat_hist, 32'h898);
      err_cr = -1; err_eq = 2;
      run(3'd4, 8'h11, 1'b0, 1'b0, 8'h0A);
      chk("R11 eq err reads", eq_idx, 3);
      chk("R11 eq drive writes", n_drv, 3);
      chk("R11 eq fail", pass, 0);
   endtask

   initial begin
      set_adj(0,0, 0,0, 0,0, 0,0);
      st_lanes = 4; st_align = 1; cr_ok_at = 0; eq_ok_at = 0; err_cr = -1; err_eq = -1;
      phase = 0;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_happy();
      t_tp3_inactive();
      t_cr_same();
      t_max_swing();
      t_eq_limit();
      t_align();
      t_rd_err();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule